// File: doc/BRIEF.md
# Extended-Capability Register Bank with Test FIFO

This block is the extended register bank of a host-side parallel port controller. It holds three things. The first is a mode register that picks how the port behaves. The second is a spare configuration byte. The third is a two-entry byte FIFO that software can fill and drain directly while the mode register selects FIFO-test mode. The host reaches all of it over a simple byte bus with a read strobe, a write strobe and a three-bit offset.

Read data is combinational from the state the bank holds before the clock edge. Write and pop side effects take place at that edge. The bank keeps the FIFO status flags in the mode register up to date. Any change of mode empties the FIFO. At offset 0, reads and writes drain and fill the FIFO in test mode. In every other mode, offset 0 reaches an ordinary holding register.

Top module: `xcap_regbank`

## Requirements
- R1: After reset, offset 2 reads 0x01 (mode 0, FIFO empty), offset 1 reads 0x00 and offset 0 reads 0x00, and both FIFO pointers are 0.
- R2: Offset 2 layout: bits 7:5 hold the mode (0 compatible, 1 byte, 2 PP-FIFO, 3 ECP-FIFO, 4 EPP, 5 reserved, 6 FIFO-test, 7 configuration), bits 4:2 read 0, and bits 1:0 are the FIFO status (01 empty, 10 full, 00 holding some data; 11 never occurs). A write to offset 2 replaces bits 7:5 with the written bits 7:5, and the written bits 4:0 have no effect.
- R3: A write to offset 2 whose mode differs from the current mode resets both FIFO pointers and leaves the FIFO empty. A write that carries the same mode leaves the FIFO contents and flags unchanged.
- R4: In mode 6, a write to offset 0 stores the byte at the write pointer and advances it, wrapping to 0 after the last entry. The status then shows full when all FIFO_DEPTH entries are occupied, and otherwise some data.
- R5: In mode 6, a read from offset 0 returns the entry at the read pointer and advances it, wrapping to 0. The status shows empty once no entries remain, and otherwise some data.
- R6: In mode 6, a write to offset 0 while the FIFO is full has no effect on contents, pointers or flags.
- R7: In mode 6, a read from offset 0 while the FIFO is empty returns the entry at the read pointer and moves no pointer, and the status stays empty.
- R8: Outside mode 6, offset 0 is a read/write holding register that does not touch the FIFO. Its value survives periods spent in mode 6.
- R9: Offset 1 is a read/write configuration byte.
- R10: Reads from offsets 3 to 7 return 0xFF, and writes to them change no register.
- R11: When both strobes are high in one cycle, the read returns the state before the edge. In mode 6 at offset 0, the pop acts only if the FIFO was not empty and the push acts only if it was not full, both judged before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed offset |
| rd_en | input | 1 | Read strobe; a read at offset 0 in mode 6 pops |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, valid while `rd_en` is high |

## Verification
A read and a write can fall in the same cycle. The case that matters is offset 0 in test mode, where a pop and a push then meet. The bench raises both strobes together in three FIFO states: one entry held, empty, and at offset 2 during a mode change. In each case it expects the read to return the pre-edge entry or register value. It then reads the status and drains the FIFO, and expects the occupancy and order that follow from gating the pop on the old empty flag and the push on the old full flag.

// File: rtl/xcap_pkg.sv
package xcap_pkg;

    typedef enum logic [2:0] {
        MODE_COMPAT  = 3'd0,
        MODE_BYTE    = 3'd1,
        MODE_PPFIFO  = 3'd2,
        MODE_ECPFIFO = 3'd3,
        MODE_EPP     = 3'd4,
        MODE_RSVD    = 3'd5,
        MODE_TEST    = 3'd6,
        MODE_CONFIG  = 3'd7
    } xcap_mode_e;

    localparam int OFS_DATA = 0;
    localparam int OFS_CFGB = 1;
    localparam int OFS_ECR  = 2;

    localparam logic [1:0] FLAGS_SOME  = 2'b00;
    localparam logic [1:0] FLAGS_EMPTY = 2'b01;
    localparam logic [1:0] FLAGS_FULL  = 2'b10;

endpackage

// File: rtl/xcap_fifo.sv
module xcap_fifo #(
    parameter int DW         = 8,
    parameter int FIFO_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    typedef struct packed {
        logic [FIFO_DEPTH-1:0][DW-1:0] mem;
        logic [PTR_W-1:0]              wp;
        logic [PTR_W-1:0]              rp;
        logic [CNT_W-1:0]              cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic        push_ok, pop_ok;

    always_comb begin
        s_d     = s_q;
        empty   = (s_q.cnt == '0);
        full    = (s_q.cnt == FULL_CNT);
        head    = s_q.mem[s_q.rp];
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (push_ok) begin
                s_d.mem[s_q.wp] = wdata;
                s_d.wp = (s_q.wp == LAST_PTR) ? '0 : s_q.wp + PTR_W'(1);
            end
            if (pop_ok) begin
                s_d.rp = (s_q.rp == LAST_PTR) ? '0 : s_q.rp + PTR_W'(1);
            end
            s_d.cnt = s_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/xcap_ctrl_regs.sv
module xcap_ctrl_regs
    import xcap_pkg::*;
#(
    parameter int DW     = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output xcap_mode_e        mode,
    output logic [DW-1:0]     cfgb,
    output logic [DW-1:0]     hold,
    output logic              mode_change
);
    typedef struct packed {
        xcap_mode_e    mode;
        logic [DW-1:0] cfgb;
        logic [DW-1:0] hold;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;
    logic [2:0]  new_mode;

    always_comb begin
        s_d         = s_q;
        new_mode    = wdata[DW-1 -: 3];
        mode_change = 1'b0;
        if (wr_en) begin
            if (addr == ADDR_W'(OFS_ECR)) begin
                mode_change = (new_mode != s_q.mode);
                s_d.mode    = xcap_mode_e'(new_mode);
            end else if (addr == ADDR_W'(OFS_CFGB)) begin
                s_d.cfgb = wdata;
            end else if (addr == ADDR_W'(OFS_DATA) && s_q.mode != MODE_TEST) begin
                s_d.hold = wdata;
            end
        end
        mode = s_q.mode;
        cfgb = s_q.cfgb;
        hold = s_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{mode: MODE_COMPAT, cfgb: '0, hold: '0};
        else        s_q <= s_d;
    end

endmodule

// File: rtl/xcap_regbank.sv
module xcap_regbank
    import xcap_pkg::*;
#(
    parameter int DW         = 8,
    parameter int ADDR_W     = 3,
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    localparam int PAD_W = DW - 5;

    xcap_mode_e    mode;
    logic [DW-1:0] cfgb, hold, fifo_head;
    logic          mode_change, fifo_empty, fifo_full;
    logic          test_mode, at_data, fifo_push, fifo_pop;
    logic [1:0]    flags;

    assign test_mode = (mode == MODE_TEST);
    assign at_data   = (addr == ADDR_W'(OFS_DATA));
    assign fifo_push = wr_en && at_data && test_mode;
    assign fifo_pop  = rd_en && at_data && test_mode;

    xcap_ctrl_regs #(.DW(DW), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .mode        (mode),
        .cfgb        (cfgb),
        .hold        (hold),
        .mode_change (mode_change)
    );

    xcap_fifo #(.DW(DW), .FIFO_DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .flush (mode_change),
        .wdata (wdata),
        .head  (fifo_head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    always_comb begin
        if (fifo_empty)     flags = FLAGS_EMPTY;
        else if (fifo_full) flags = FLAGS_FULL;
        else                flags = FLAGS_SOME;
        rdata = '1;
        case (addr)
            ADDR_W'(OFS_DATA): rdata = test_mode ? fifo_head : hold;
            ADDR_W'(OFS_CFGB): rdata = cfgb;
            ADDR_W'(OFS_ECR):  rdata = {mode, {PAD_W{1'b0}}, flags};
            default:           rdata = '1;
        endcase
    end

endmodule

// File: rtl/xcap_regbank_chk.sv
module xcap_regbank_chk #(
    parameter int DW     = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wdata,
    input logic [DW-1:0]     rdata,
    input logic [2:0]        mode,
    input logic [DW-1:0]     cfgb,
    input logic [DW-1:0]     hold,
    input logic              fifo_empty,
    input logic              fifo_full
);
    // R2
    flags_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

    // R3
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(2) && wdata[DW-1 -: 3] != mode) |=> fifo_empty);

    // R6
    full_push_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && addr == '0 && mode == 3'd6 && fifo_full) |=> fifo_full);

    // R7
    empty_pop_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == '0 && mode == 3'd6 && fifo_empty) |=> fifo_empty);

    // R8
    hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && mode != 3'd6) |=> (hold == $past(wdata)));

    // R9
    cfgb_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(1)) |=> (cfgb == $past(wdata)));

    // R10
    undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr > ADDR_W'(2)) |-> (rdata == '1));

    // R10
    undef_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > ADDR_W'(2)) |=> ($stable(cfgb) && $stable(mode) && $stable(hold)));

endmodule

bind xcap_regbank xcap_regbank_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .mode       (mode),
    .cfgb       (cfgb),
    .hold       (hold),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full)
);

// File: tb/test_xcap_regbank.sv
module test_xcap_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    xcap_regbank i_xcap_regbank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    always #2.5 clk = ~clk;

    // monitor: compares each read against the queued expectation
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read: actual %02h expected none", rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s offset %0d: actual %02h expected %02h", t, addr, rdata, e);
                end
            end
        end
    end

    task automatic xfer(input logic w, input logic r, input logic [2:0] a,
                        input logic [7:0] d, input logic [7:0] e, input string t);
        wr_en = w;
        rd_en = r;
        addr  = a;
        wdata = d;
        if (r) begin
            exp_q.push_back(e);
            tag_q.push_back(t);
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        xfer(1'b1, 1'b0, a, d, 8'h00, "");
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        xfer(1'b0, 1'b1, a, 8'h00, e, t);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(100000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 reset state
        rd(3'd2, 8'h01, "R1");
        rd(3'd1, 8'h00, "R1");
        rd(3'd0, 8'h00, "R1");
        // R8 / R9 plain registers in compatible mode
        wr(3'd0, 8'h5A);
        rd(3'd0, 8'h5A, "R8");
        wr(3'd1, 8'hC3);
        rd(3'd1, 8'hC3, "R9");
        // R2 enter test mode, low bits of write ignored
        wr(3'd2, 8'hDF);
        rd(3'd2, 8'hC1, "R2");
        // R7 pop while empty
        rd(3'd0, 8'h00, "R7");
        rd(3'd2, 8'hC1, "R7");
        // R4 fill
        wr(3'd0, 8'h11);
        rd(3'd2, 8'hC0, "R4");
        wr(3'd0, 8'h22);
        rd(3'd2, 8'hC2, "R4");
        // R6 push while full
        wr(3'd0, 8'h33);
        rd(3'd2, 8'hC2, "R6");
        // R5 drain in order
        rd(3'd0, 8'h11, "R5");
        rd(3'd2, 8'hC0, "R5");
        rd(3'd0, 8'h22, "R6");
        rd(3'd2, 8'hC1, "R5");
        // R7 pop while empty after wrap returns entry at read pointer 0
        rd(3'd0, 8'h11, "R7");
        rd(3'd2, 8'hC1, "R7");
        // R11 push and pop together with one entry held
        wr(3'd0, 8'h44);
        xfer(1'b1, 1'b1, 3'd0, 8'h55, 8'h44, "R11");
        rd(3'd2, 8'hC0, "R11");
        rd(3'd0, 8'h55, "R11");
        rd(3'd2, 8'hC1, "R11");
        // R11 push and pop together while empty: only the push acts
        xfer(1'b1, 1'b1, 3'd0, 8'h66, 8'h44, "R11");
        rd(3'd2, 8'hC0, "R11");
        rd(3'd0, 8'h66, "R11");
        // R3 same-mode write keeps contents, new mode flushes
        wr(3'd0, 8'h77);
        wr(3'd2, 8'hC0);
        rd(3'd2, 8'hC0, "R3");
        wr(3'd2, 8'h20);
        rd(3'd2, 8'h21, "R3");
        wr(3'd2, 8'hC0);
        rd(3'd2, 8'hC1, "R3");
        rd(3'd0, 8'h66, "R3");
        // R8 holding register survives test mode, FIFO untouched outside it
        wr(3'd2, 8'h00);
        rd(3'd0, 8'h5A, "R8");
        wr(3'd2, 8'h60);
        wr(3'd0, 8'hA5);
        rd(3'd0, 8'hA5, "R8");
        rd(3'd2, 8'h61, "R8");
        // R10 undefined offsets
        for (int i = 3; i < 8; i++) wr(3'(i), 8'h00);
        for (int i = 3; i < 8; i++) rd(3'(i), 8'hFF, "R10");
        rd(3'd1, 8'hC3, "R10");
        rd(3'd2, 8'h61, "R10");
        rd(3'd0, 8'hA5, "R10");
        // R11 read and write of offset 2 together: read sees old value
        xfer(1'b1, 1'b1, 3'd2, 8'hE0, 8'h61, "R11");
        rd(3'd2, 8'hE1, "R2");
        @(posedge clk);
        #1;
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule